// File: doc/BRIEF.md
# Transport Timeout Supervisor

This block checks that a motor-driven transport step finishes within a fixed time. A one-cycle go pulse arms a timeout counter. A one-cycle done pulse disarms it. If the counter reaches its terminal value before the done pulse arrives, the block raises a timeout pulse for exactly one cycle and disarms itself. It does not free-run and it does not wrap.

The inputs are already single-cycle pulses, so the block does no edge detection. It also does not latch the error or wait for an acknowledge; whatever consumes the timeout pulse is responsible for that. The `busy` output shows whether a supervision interval is in progress.

The terminal count `TERM` is a parameter and the counter width is derived from it. With an 8192 Hz clock, the default of 16383 gives a timeout of about two seconds in a 14-bit counter. A small value keeps simulation short.

Top module: `motor_timeout_supervisor`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `busy` and `timeout` are both 0.
- R2: `busy` is 1 after the clock edge that samples `go` high.
- R3: A `done` pulse sampled on edge d after the arming edge, with 1 <= d <= TERM, drives `busy` to 0 after edge d. No `timeout` pulse follows.
- R4: With no `done` pulse, `timeout` is 1 only after edge TERM+1 counted from the arming edge, and it is 0 after the following edge.
- R5: `busy` falls on the same edge on which `timeout` rises.
- R6: A `go` pulse while `busy` is 1 restarts the interval. The timeout then follows TERM+1 edges after that second `go` pulse, and the first interval produces no timeout.
- R7: When `go` and `done` are high in the same cycle, `go` takes priority and the interval restarts from zero.
- R8: A `done` pulse while idle has no effect: `busy` and `timeout` stay 0, and a later `go` still times out after TERM+1 edges.
- R9: A `done` pulse sampled on edge TERM+1, the edge on which the timeout would fire, wins. `busy` falls and no `timeout` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | One-cycle pulse that starts or restarts supervision |
| done | input | 1 | One-cycle pulse that signals the transport finished |
| timeout | output | 1 | One-cycle pulse when the interval expires |
| busy | output | 1 | High while a supervision interval is armed |

## Verification
The bench uses a small terminal count and runs three sweeps:

- **Done delay sweep.** The `done` pulse is placed at every delay from one edge up to past expiry. This separates early completion, completion on the terminal edge, and a true timeout, and it checks the exact edge of the single `timeout` pulse.
- **Restart sweep.** A second `go` pulse is placed at every point of a running interval, both alone and together with `done`. This shows that the interval restarts from zero and that `go` has priority.
- **Idle done pulses.** Stray `done` pulses are applied while idle, followed by a normal expiry. This shows that the stray pulses leave the state untouched.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } arm_state_e;

  // Width needed to hold values 0..term
  function automatic int cnt_width(input int term);
    int w;
    w = $clog2(term + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/mtt_tick_counter.sv
module mtt_tick_counter #(
  parameter int TERM = 16383
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic at_term
);

  localparam int W = mtt_pkg::cnt_width(TERM);
  localparam logic [W-1:0] TERM_V = W'(TERM);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || en) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_term = (cnt_q == TERM_V);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM_V);

endmodule

// File: rtl/mtt_arm_ctrl.sv
module mtt_arm_ctrl
  import mtt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic done,
  input  logic at_term,
  output logic cnt_clr,
  output logic cnt_en,
  output logic busy,
  output logic timeout
);

  arm_state_e state_q, state_d;
  logic       tmo_q, tmo_d;
  logic       expire;

  assign expire = (state_q == ST_ARMED) && at_term && !go && !done;

  always_comb begin
    state_d = state_q;
    tmo_d   = 1'b0;
    if (go) begin
      state_d = ST_ARMED;
    end else if (done) begin
      state_d = ST_IDLE;
    end else if (expire) begin
      state_d = ST_IDLE;
      tmo_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
    end
  end

  assign cnt_clr = go;
  assign cnt_en  = (state_q == ST_ARMED) && !at_term;
  assign busy    = (state_q == ST_ARMED);
  assign timeout = tmo_q;

  // R2
  go_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R3
  done_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> (!busy && !timeout));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !busy);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> !timeout);

endmodule

// File: rtl/motor_timeout_supervisor.sv
module motor_timeout_supervisor #(
  parameter int TERM = 16383
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic done,
  output logic timeout,
  output logic busy
);

  logic at_term;
  logic cnt_clr;
  logic cnt_en;

  mtt_tick_counter #(
    .TERM(TERM)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .en      (cnt_en),
    .at_term (at_term)
  );

  mtt_arm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .done    (done),
    .at_term (at_term),
    .cnt_clr (cnt_clr),
    .cnt_en  (cnt_en),
    .busy    (busy),
    .timeout (timeout)
  );

  // R4
  pulse_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(busy));

endmodule

// File: tb/tb_motor_timeout_supervisor.sv
module tb_motor_timeout_supervisor;

  localparam int TERM = 12;

  logic clk;
  logic rst_n;
  logic go;
  logic done;
  logic timeout;
  logic busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  motor_timeout_supervisor #(.TERM(TERM)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .done    (done),
    .timeout (timeout),
    .busy    (busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic r);
    go   = s;
    done = r;
    @(posedge clk);
    @(negedge clk);
    go   = 1'b0;
    done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    go    = 1'b0;
    done  = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs held low in reset
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "timeout in reset", timeout, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", busy, 1'b0);
    chk("R1", "timeout after release", timeout, 1'b0);

    // Sweep of done delay: R2 R3 R4 R5 R9
    for (int d = 1; d <= TERM + 3; d++) begin
      cyc(1'b1, 1'b0);
      chk("R2", "busy after go", busy, 1'b1);
      for (int j = 1; j <= TERM + 3; j++) begin
        logic exp_err;
        logic exp_busy;
        cyc(1'b0, j == d);
        exp_err  = (d > TERM + 1) && (j == TERM + 1);
        exp_busy = (j < d) && (j <= TERM);
        if (d == TERM + 1 && j == TERM + 1)
          chk("R9", "timeout when done on terminal edge", timeout, exp_err);
        else if (d <= TERM)
          chk("R3", "timeout after early done", timeout, exp_err);
        else
          chk("R4", "timeout pulse timing", timeout, exp_err);
        if (j >= d)
          chk("R3", "busy after done", busy, exp_busy);
        else
          chk("R5", "busy while timing", busy, exp_busy);
      end
    end

    // Restart sweep: R6 (go alone), R7 (go with done)
    for (int both = 0; both <= 1; both++) begin
      for (int k = 1; k <= TERM + 1; k++) begin
        cyc(1'b1, 1'b0);
        for (int j = 1; j <= k + TERM + 2; j++) begin
          logic exp_err;
          logic exp_busy;
          cyc(j == k, (both == 1) && (j == k));
          exp_err  = (j == k + TERM + 1);
          exp_busy = (j <= k + TERM);
          if (both == 1) begin
            chk("R7", "timeout after go+done restart", timeout, exp_err);
            chk("R7", "busy after go+done restart", busy, exp_busy);
          end else begin
            chk("R6", "timeout after restart", timeout, exp_err);
            chk("R6", "busy after restart", busy, exp_busy);
          end
        end
      end
    end

    // Idle done pulses: R8
    for (int n = 0; n < 4; n++) begin
      cyc(1'b0, 1'b1);
      chk("R8", "busy after idle done", busy, 1'b0);
      chk("R8", "timeout after idle done", timeout, 1'b0);
    end
    cyc(1'b1, 1'b0);
    for (int j = 1; j <= TERM + 2; j++) begin
      cyc(1'b0, 1'b0);
      chk("R8", "timeout timing after idle done", timeout, j == TERM + 1);
      chk("R8", "busy timing after idle done", busy, j <= TERM);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule